// File: doc/BRIEF.md
# Memory Operation Retry Buffer

This block sits between a core's issue stage and its load/store queue. A memory instruction that has been issued leaves the issue window and is parked here; the buffer then offers its stored operations to the load/store queue one at a time, always the oldest first. The queue may refuse an offer when it has no free slot. A refused operation is kept and offered again on the next cycle. An operation is released only in a cycle in which the queue accepts it.

Each stored operation carries its kind (load or store), address, store data, its position inside its code block and the identifier of that block. When a block is squashed, a flush request names the block identifier and every stored operation of that block is discarded in one cycle, while the remaining operations keep their relative age. When every slot is taken, the buffer withdraws its ready signal so that issue stops sending memory instructions. The asynchronous active-low reset is synchronised inside the block before it is released.

Top module: `mskid_buffer`

## Requirements
- R1: After reset the buffer is empty: `lsq_req` is low, `iss_ready` is high and `buf_full` is low.
- R2: An operation taken in when `iss_valid` and `iss_ready` are both high is later offered with its fields unchanged; `lsq_op` value 0 means load and 1 means store.
- R3: Operations are offered in the order they were taken in; only the oldest stored operation is ever offered.
- R4: When `lsq_req` is high and `lsq_accept` is low (a refusal), the same operation is offered again in the next cycle with identical fields, unless a flush removes it.
- R5: When `lsq_req` and `lsq_accept` are both high at a clock edge, exactly that operation is removed and the next oldest is offered in the following cycle.
- R6: With DEPTH operations stored, `iss_ready` is low and `buf_full` is high, and an offered operation is not stored; ready follows the occupancy held in registers, so an acceptance in the same cycle frees space only from the next cycle on.
- R7: A flush removes every stored operation whose block identifier equals `flush_bid`, and also drops an incoming operation of that block in the same cycle; the survivors keep their order.
- R8: In a flush cycle whose oldest operation belongs to the flushed block, `lsq_req` is low and `lsq_accept` has no effect.
- R9: An operation taken into an empty buffer is offered in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue offers a memory operation |
| iss_ready | output | 1 | Buffer can take an operation |
| iss_op | input | 1 | Operation kind, 0 load, 1 store |
| iss_addr | input | ADDR_W | Memory address |
| iss_data | input | DATA_W | Store data |
| iss_idx | input | IDX_W | Instruction position inside its block |
| iss_bid | input | BID_W | Block identifier |
| buf_full | output | 1 | All slots occupied |
| lsq_req | output | 1 | Oldest operation offered to the queue |
| lsq_op | output | 1 | Offered operation kind |
| lsq_addr | output | ADDR_W | Offered address |
| lsq_data | output | DATA_W | Offered store data |
| lsq_idx | output | IDX_W | Offered instruction position |
| lsq_bid | output | BID_W | Offered block identifier |
| lsq_accept | input | 1 | Queue allocates the offered operation; low while `lsq_req` is high is a refusal |
| flush_valid | input | 1 | Squash request |
| flush_bid | input | BID_W | Block identifier to squash |

## Verification
The bench builds the buffer with DEPTH=4, 16-bit address and data, a 5-bit instruction position and a 2-bit block identifier. Four slots make the full condition, the refused enqueue at full and the full-cycle acceptance reachable within a handful of cycles, and two identifier bits allow several live blocks so that a flush can remove entries at the head and in the middle while leaving older and younger survivors in order.

// File: rtl/mskid_pkg.sv
package mskid_pkg;

  typedef enum logic {
    MEM_LOAD  = 1'b0,
    MEM_STORE = 1'b1
  } mem_op_e;

endpackage

// File: rtl/mskid_rst_sync.sv
module mskid_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/mskid_rank.sv
module mskid_rank #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0]            keep,
  output logic [DEPTH-1:0][CNT_W-1:0] pos,
  output logic [CNT_W-1:0]            total
);

  assign pos[0] = '0;

  for (genvar k = 1; k < DEPTH; k++) begin : g_prefix
    assign pos[k] = pos[k-1] + CNT_W'(keep[k-1]);
  end

  assign total = pos[DEPTH-1] + CNT_W'(keep[DEPTH-1]);

endmodule

// File: rtl/mskid_slot.sv
module mskid_slot #(
  parameter int ENT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_d,
  input  logic             ld,
  input  logic [ENT_W-1:0] d,
  output logic             vld_q,
  output logic [ENT_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (ld) q <= d;
  end

endmodule

// File: rtl/mskid_buffer.sv
module mskid_buffer #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7,
  parameter int BID_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic              iss_op,
  input  logic [ADDR_W-1:0] iss_addr,
  input  logic [DATA_W-1:0] iss_data,
  input  logic [IDX_W-1:0]  iss_idx,
  input  logic [BID_W-1:0]  iss_bid,
  output logic              buf_full,
  output logic              lsq_req,
  output logic              lsq_op,
  output logic [ADDR_W-1:0] lsq_addr,
  output logic [DATA_W-1:0] lsq_data,
  output logic [IDX_W-1:0]  lsq_idx,
  output logic [BID_W-1:0]  lsq_bid,
  input  logic              lsq_accept,
  input  logic              flush_valid,
  input  logic [BID_W-1:0]  flush_bid
);
  import mskid_pkg::*;

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = 1 + BID_W + IDX_W + ADDR_W + DATA_W;
  localparam int BID_HI = ENT_W - 2;

  logic                            rst_n_sync;
  logic [DEPTH-1:0]                vld_q;
  logic [DEPTH-1:0]                vld_d;
  logic [DEPTH-1:0]                ld;
  logic [DEPTH-1:0][ENT_W-1:0]     ent_q;
  logic [DEPTH-1:0][ENT_W-1:0]     ent_d;
  logic [DEPTH-1:0]                keep;
  logic [DEPTH-1:0][CNT_W-1:0]     pos;
  logic [CNT_W-1:0]                total;
  logic [ENT_W-1:0]                in_ent;
  mem_op_e                         in_op;
  mem_op_e                         head_op;
  logic                            head_squash;
  logic                            pop;
  logic                            enq_take;

  mskid_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Edge signals
  assign in_op       = mem_op_e'(iss_op);
  assign in_ent      = {in_op, iss_bid, iss_idx, iss_addr, iss_data};
  assign iss_ready   = !vld_q[DEPTH-1];
  assign buf_full    = vld_q[DEPTH-1];
  assign head_squash = flush_valid && (ent_q[0][BID_HI -: BID_W] == flush_bid);
  assign lsq_req     = vld_q[0] && !head_squash;
  assign pop         = lsq_req && lsq_accept;
  assign enq_take    = iss_valid && iss_ready && !(flush_valid && (iss_bid == flush_bid));

  assign head_op = mem_op_e'(ent_q[0][ENT_W-1]);
  assign lsq_op  = head_op;
  assign {lsq_bid, lsq_idx, lsq_addr, lsq_data} = ent_q[0][ENT_W-2:0];

  // Which stored entries survive this cycle
  for (genvar k = 0; k < DEPTH; k++) begin : g_keep
    always_comb begin
      keep[k] = vld_q[k];
      if (flush_valid && (ent_q[k][BID_HI -: BID_W] == flush_bid)) keep[k] = 1'b0;
      if ((k == 0) && pop) keep[k] = 1'b0;
    end
  end

  mskid_rank #(.DEPTH(DEPTH)) u_rank (
    .keep  (keep),
    .pos   (pos),
    .total (total)
  );

  // Compacting next state: slot j takes the survivor ranked j, or the new entry
  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic             hit;
    logic [ENT_W-1:0] pick;
    logic             enq_here;

    always_comb begin
      hit  = 1'b0;
      pick = '0;
      for (int k = j; k < DEPTH; k++) begin
        if (keep[k] && (pos[k] == CNT_W'(j))) begin
          hit  = 1'b1;
          pick = ent_q[k];
        end
      end
      enq_here = enq_take && (total == CNT_W'(j));
      vld_d[j] = hit || enq_here;
      ld[j]    = hit || enq_here;
      ent_d[j] = enq_here ? in_ent : pick;
    end

    mskid_slot #(.ENT_W(ENT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .vld_d (vld_d[j]),
      .ld    (ld[j]),
      .d     (ent_d[j]),
      .vld_q (vld_q[j]),
      .q     (ent_q[j])
    );
  end

  // Checks
  assert_compact_R3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ((vld_q & (vld_q + 1'b1)) == '0));

  assert_nack_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (lsq_req && !lsq_accept && !flush_valid) |=>
      (flush_valid || (lsq_req && $stable(lsq_addr) && $stable(lsq_data) &&
                       $stable(lsq_idx) && $stable(lsq_bid) && $stable(lsq_op))));

  assert_accept_pop_R5: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (lsq_req && lsq_accept && !flush_valid && !(iss_valid && iss_ready)) |=>
      ($countones(vld_q) == $countones($past(vld_q)) - 1));

  assert_full_block_R6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ($countones(vld_q) == DEPTH) |-> (!iss_ready && buf_full));

  assert_flush_clean_R7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    flush_valid |=> !(lsq_req && (lsq_bid == $past(flush_bid))));

  assert_enq_visible_R9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (iss_valid && iss_ready && !vld_q[0] && !flush_valid) |=>
      (flush_valid || (lsq_req && (lsq_addr == $past(iss_addr)))));

endmodule

// File: tb/mskid_buffer_tb.sv
module mskid_buffer_tb;

  localparam int DEPTH = 4;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int IW = 5;
  localparam int BW = 2;
  localparam int NV = 13;

  // rq[28:25] iv[24] bid[23:22] tag[21:14] acc[13] fv[12] fbid[11:10] ereq[9] etag[8:1] erdy[0]
  localparam logic [28:0] VEC [NV] = '{
    {4'd9, 1'b1, 2'd0, 8'd1, 1'b0, 1'b0, 2'd0, 1'b0, 8'd0, 1'b1}, // R9 first entry
    {4'd4, 1'b1, 2'd1, 8'd2, 1'b0, 1'b0, 2'd0, 1'b1, 8'd1, 1'b1}, // R4 refused
    {4'd5, 1'b1, 2'd0, 8'd3, 1'b1, 1'b0, 2'd0, 1'b1, 8'd1, 1'b1}, // R5 accept
    {4'd3, 1'b1, 2'd2, 8'd4, 1'b0, 1'b0, 2'd0, 1'b1, 8'd2, 1'b1}, // R3 order
    {4'd3, 1'b1, 2'd1, 8'd5, 1'b0, 1'b0, 2'd0, 1'b1, 8'd2, 1'b1}, // R3 fills
    {4'd6, 1'b1, 2'd0, 8'd6, 1'b0, 1'b0, 2'd0, 1'b1, 8'd2, 1'b0}, // R6 refused at full
    {4'd5, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 2'd0, 1'b1, 8'd2, 1'b0}, // R5
    {4'd8, 1'b1, 2'd0, 8'd7, 1'b1, 1'b1, 2'd0, 1'b0, 8'd0, 1'b1}, // R8 head squashed
    {4'd7, 1'b1, 2'd3, 8'd8, 1'b0, 1'b0, 2'd0, 1'b1, 8'd4, 1'b1}, // R7 survivors
    {4'd7, 1'b0, 2'd0, 8'd0, 1'b1, 1'b1, 2'd1, 1'b1, 8'd4, 1'b1}, // R7 mid flush
    {4'd7, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 2'd0, 1'b1, 8'd8, 1'b1}, // R7
    {4'd5, 1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 2'd0, 1'b1, 8'd8, 1'b1}, // R5
    {4'd5, 1'b0, 2'd0, 8'd0, 1'b0, 1'b0, 2'd0, 1'b0, 8'd0, 1'b1}  // R5 empty
  };

  logic          clk;
  logic          rst_n;
  logic          iss_valid, iss_ready, iss_op, buf_full;
  logic [AW-1:0] iss_addr, lsq_addr;
  logic [DW-1:0] iss_data, lsq_data;
  logic [IW-1:0] iss_idx, lsq_idx;
  logic [BW-1:0] iss_bid, lsq_bid, flush_bid;
  logic          lsq_req, lsq_op, lsq_accept, flush_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  mskid_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .BID_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_addr(iss_addr), .iss_data(iss_data), .iss_idx(iss_idx), .iss_bid(iss_bid),
    .buf_full(buf_full), .lsq_req(lsq_req), .lsq_op(lsq_op), .lsq_addr(lsq_addr),
    .lsq_data(lsq_data), .lsq_idx(lsq_idx), .lsq_bid(lsq_bid), .lsq_accept(lsq_accept),
    .flush_valid(flush_valid), .flush_bid(flush_bid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check the outputs it sees before the rising edge
  task automatic step(input string rq, input logic iv, input logic [1:0] bid, input logic [7:0] tag,
                      input logic acc, input logic fv, input logic [1:0] fb,
                      input logic ereq, input logic [7:0] etag, input logic erdy);
    @(negedge clk);
    iss_valid   = iv;
    iss_bid     = bid;
    iss_addr    = 16'h0100 + AW'(tag);
    iss_data    = {8'hA5, tag};
    iss_idx     = tag[IW-1:0];
    iss_op      = tag[0];
    lsq_accept  = acc;
    flush_valid = fv;
    flush_bid   = fb;
    #1;
    chk(rq, "lsq_req", 32'(lsq_req), 32'(ereq));
    chk(rq, "iss_ready", 32'(iss_ready), 32'(erdy));
    chk(rq, "buf_full", 32'(buf_full), 32'(!erdy));
    if (ereq) begin
      chk(rq, "lsq_addr", 32'(lsq_addr), 32'(16'h0100 + AW'(etag)));
      chk({rq, " R2"}, "lsq_data", 32'(lsq_data), 32'({8'hA5, etag}));
      chk({rq, " R2"}, "lsq_idx", 32'(lsq_idx), 32'(etag[IW-1:0]));
      chk({rq, " R2"}, "lsq_op", 32'(lsq_op), 32'(etag[0]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    iss_valid = 0; iss_op = 0; iss_addr = '0; iss_data = '0; iss_idx = '0; iss_bid = '0;
    lsq_accept = 0; flush_valid = 0; flush_bid = '0;
    do_reset();
    #1;
    // R1 reset state
    chk("R1", "lsq_req", 32'(lsq_req), 32'd0);
    chk("R1", "iss_ready", 32'(iss_ready), 32'd1);
    chk("R1", "buf_full", 32'(buf_full), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      step($sformatf("R%0d", v[28:25]), v[24], v[23:22], v[21:14], v[13], v[12], v[11:10],
           v[9], v[8:1], v[0]);
    end

    // R6: acceptance while full does not reopen ready in the same cycle
    step("R6", 1, 2'd2, 8'd20, 0, 0, 2'd0, 0, 8'd0, 1);
    step("R6", 1, 2'd2, 8'd21, 0, 0, 2'd0, 1, 8'd20, 1);
    step("R6", 1, 2'd2, 8'd22, 0, 0, 2'd0, 1, 8'd20, 1);
    step("R6", 1, 2'd2, 8'd23, 0, 0, 2'd0, 1, 8'd20, 1);
    step("R6", 1, 2'd2, 8'd24, 1, 0, 2'd0, 1, 8'd20, 0);
    step("R6", 1, 2'd2, 8'd24, 0, 0, 2'd0, 1, 8'd21, 1);
    step("R3", 0, 2'd0, 8'd0, 1, 0, 2'd0, 1, 8'd21, 0);
    step("R3", 0, 2'd0, 8'd0, 1, 0, 2'd0, 1, 8'd22, 1);
    step("R3", 0, 2'd0, 8'd0, 1, 0, 2'd0, 1, 8'd23, 1);
    step("R3", 0, 2'd0, 8'd0, 1, 0, 2'd0, 1, 8'd24, 1);
    step("R5", 0, 2'd0, 8'd0, 0, 0, 2'd0, 0, 8'd0, 1);

    // R7/R8: flush at head with a same-block and a different-block incoming op
    step("R7", 1, 2'd1, 8'd30, 0, 0, 2'd0, 0, 8'd0, 1);
    step("R7", 1, 2'd2, 8'd31, 0, 0, 2'd0, 1, 8'd30, 1);
    step("R7", 1, 2'd1, 8'd32, 0, 0, 2'd0, 1, 8'd30, 1);
    step("R8", 1, 2'd2, 8'd33, 1, 1, 2'd1, 0, 8'd0, 1);
    step("R7", 1, 2'd1, 8'd34, 1, 1, 2'd1, 1, 8'd31, 1);
    step("R7", 0, 2'd0, 8'd0, 1, 0, 2'd0, 1, 8'd33, 1);
    step("R7", 0, 2'd0, 8'd0, 0, 0, 2'd0, 0, 8'd0, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule